// File: doc/BRIEF.md
# Demand-Class Helper Assignment Arbiter

This block decides which instance of a shared helper each core uses, for a pool of helpers of a single type that several cores share. Every core presents a request bit, already filtered by upstream usefulness counters, and a 16-bit demand count. When the phase-change strobe arrives, the block takes a snapshot of these inputs and sorts each core's demand into a light, medium or heavy class using two programmable thresholds. It then maps every requesting core to a helper instance. The classes stay in the snapshot until the next strobe, so they belong to the phase that was just entered.

Two placement policies are available, chosen by a mode input. The first is for helpers that are only used on demand, such as caches or a branch target buffer. Here the block spreads the heaviest users over different instances. The second is for helpers that are always active, such as prefetchers or value predictors. Here the block groups cores of similar class together and, when possible, gives a heavy core an instance of its own. A core that does not request gets no instance.

A small state machine runs the computation. ST_IDLE waits for the strobe and takes the snapshot, then moves to ST_RANK. ST_RANK registers each requester's sort rank, then moves to ST_PLACE. ST_PLACE writes the assignment outputs and returns to ST_IDLE. The outputs change only in ST_PLACE, two clock edges after the edge that sampled the strobe.

Top module: `hp_assign_top`

## Requirements
- R1: After reset every valid bit is 0 and every instance index is 0.
- R2: A core whose demand is at least the high threshold is heavy. A core whose demand is below the low threshold and not heavy is light. Every other core is medium. For example, with thresholds 100 and 1000, the demands 99, 100, 999 and 1000 give light, medium, medium and heavy.
- R3: A core whose request bit was 0 in the snapshot has valid 0 and index 0. A requesting core has valid 1.
- R4: When the number of requesters is at most the number of instances, the requesters get instances 0, 1, 2 and so on in ascending core-index order.
- R5: In on-demand mode (mode input 0) with more requesters than instances, the requesters are sorted by class from heavy to light, with ties going to the lower core index first. The requester at sorted position p gets instance p modulo the instance count.
- R6: In always-active mode (mode input 1) with more requesters than instances, at least one heavy requester and at least two instances, sorted position 0 alone gets instance 0. Sorted position p ≥ 1 gets instance 1 + floor((p−1)·(I−1)/(n−1)), where I is the instance count and n the requester count.
- R7: In always-active mode with more requesters than instances and no heavy requester, sorted position p gets instance floor(p·I/n).
- R8: Outputs change only on the second clock edge after the edge that samples the strobe high in ST_IDLE. Input changes without a strobe have no effect.
- R9: A strobe that arrives while a computation is in progress (ST_RANK or ST_PLACE) is ignored.
- R10: The threshold values in effect are the ones present at the strobe, so reprogramming the thresholds can change the class of the same demand count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| recompute | input | 1 | Phase-change strobe that starts a new assignment |
| mode_always | input | 1 | 1 selects the always-active policy, 0 the on-demand policy |
| thr_lo | input | 16 | Lower class threshold |
| thr_hi | input | 16 | Upper class threshold |
| req | input | 4 | Per-core request bit after usefulness filtering |
| demand | input | 64 | Per-core 16-bit demand count, with core i at bits [16i+15:16i] |
| assign_idx | output | 8 | Per-core 2-bit instance index, with core i at bits [2i+1:2i] |
| assign_vld | output | 4 | Per-core valid bit for the assigned instance |

## Verification
Each demand mix is run in both policies. This separates the round-robin spreading from the grouping with a private heavy instance, and shows whether ties among equal classes are broken by lower index. Demands placed exactly on each threshold tell the two comparison boundaries apart. Sparse request masks separate the private-instance path and the non-requester path from sorted placement. Directed sequences then check the cycle in which the outputs change, that they hold without a strobe, that a strobe arriving while the block is busy is dropped, and that reprogramming the thresholds alone moves a core between the grouped and private placements.

// File: rtl/hp_assign_pkg.sv
package hp_assign_pkg;

    typedef enum logic [1:0] {
        CLS_LIGHT  = 2'd0,
        CLS_MEDIUM = 2'd1,
        CLS_HEAVY  = 2'd2
    } dem_class_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RANK  = 2'd1,
        ST_PLACE = 2'd2
    } asg_state_e;

endpackage

// File: rtl/hp_classify.sv
module hp_classify
    import hp_assign_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] demand,
    input  logic [CNT_W-1:0] thr_lo,
    input  logic [CNT_W-1:0] thr_hi,
    output logic [1:0]       cls
);

    always_comb begin
        if (demand >= thr_hi)
            cls = CLS_HEAVY;
        else if (demand < thr_lo)
            cls = CLS_LIGHT;
        else
            cls = CLS_MEDIUM;
    end

endmodule

// File: rtl/hp_rank.sv
module hp_rank
    import hp_assign_pkg::*;
#(
    parameter int NCORES = 4,
    parameter int RANK_W = 3
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               load,
    input  logic [NCORES-1:0]                  req,
    input  logic [NCORES-1:0][1:0]             cls,
    output logic [NCORES-1:0][RANK_W-1:0]      rank_q,
    output logic [NCORES-1:0][RANK_W-1:0]      ord_q,
    output logic [RANK_W-1:0]                  cnt_q,
    output logic                               heavy_q
);

    logic [NCORES-1:0][RANK_W-1:0] rank_d;
    logic [NCORES-1:0][RANK_W-1:0] ord_d;
    logic [RANK_W-1:0]             cnt_d;
    logic                          heavy_d;

    always_comb begin
        cnt_d   = '0;
        heavy_d = 1'b0;
        for (int i = 0; i < NCORES; i++) begin
            rank_d[i] = '0;
            ord_d[i]  = '0;
            if (req[i]) begin
                cnt_d = cnt_d + 1'b1;
                if (cls[i] == CLS_HEAVY)
                    heavy_d = 1'b1;
            end
            for (int j = 0; j < NCORES; j++) begin
                if (req[j] && (j != i)) begin
                    if ((cls[j] > cls[i]) || ((cls[j] == cls[i]) && (j < i)))
                        rank_d[i] = rank_d[i] + 1'b1;
                    if (j < i)
                        ord_d[i] = ord_d[i] + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rank_q  <= '0;
            ord_q   <= '0;
            cnt_q   <= '0;
            heavy_q <= 1'b0;
        end else if (load) begin
            rank_q  <= rank_d;
            ord_q   <= ord_d;
            cnt_q   <= cnt_d;
            heavy_q <= heavy_d;
        end
    end

    for (genvar g = 0; g < NCORES; g++) begin : g_rank_chk
        AST_RANK_BELOW_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
            load |=> (!req[g] || (rank_q[g] < cnt_q))); // R5
    end

endmodule

// File: rtl/hp_place.sv
module hp_place #(
    parameter int NCORES = 4,
    parameter int NINST  = 2,
    parameter int RANK_W = 3,
    parameter int IDX_W  = 2
) (
    input  logic                          mode_always,
    input  logic [NCORES-1:0]             req,
    input  logic [NCORES-1:0][RANK_W-1:0] rank,
    input  logic [NCORES-1:0][RANK_W-1:0] ord,
    input  logic [RANK_W-1:0]             cnt,
    input  logic                          any_heavy,
    output logic [NCORES-1:0][IDX_W-1:0]  idx
);

    always_comb begin
        for (int i = 0; i < NCORES; i++) begin
            int p;
            int n;
            int inst;
            p = int'(rank[i]);
            n = int'(cnt);
            if (n <= NINST)
                inst = int'(ord[i]);
            else if (!mode_always)
                inst = p % NINST;
            else if (any_heavy && (NINST > 1))
                inst = (p == 0) ? 0 : 1 + ((p - 1) * (NINST - 1)) / (n - 1);
            else
                inst = (p * NINST) / n;
            idx[i] = req[i] ? IDX_W'(inst) : '0;
        end
    end

endmodule

// File: rtl/hp_assign_top.sv
module hp_assign_top
    import hp_assign_pkg::*;
#(
    parameter int NCORES = 4,
    parameter int NINST  = 2,
    parameter int CNT_W  = 16,
    parameter int IDX_W  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      recompute,
    input  logic                      mode_always,
    input  logic [CNT_W-1:0]          thr_lo,
    input  logic [CNT_W-1:0]          thr_hi,
    input  logic [NCORES-1:0]         req,
    input  logic [NCORES*CNT_W-1:0]   demand,
    output logic [NCORES*IDX_W-1:0]   assign_idx,
    output logic [NCORES-1:0]         assign_vld
);

    localparam int RANK_W = $clog2(NCORES + 1);

    asg_state_e                    state_q, state_d;
    logic [NCORES-1:0]             req_q;
    logic [NCORES-1:0][1:0]        cls_d, cls_q;
    logic                          mode_q;
    logic [NCORES-1:0][RANK_W-1:0] rank_q, ord_q;
    logic [RANK_W-1:0]             cnt_q;
    logic                          heavy_q;
    logic [NCORES-1:0][IDX_W-1:0]  idx_d;
    logic                          take;

    for (genvar g = 0; g < NCORES; g++) begin : g_cls
        hp_classify #(.CNT_W(CNT_W)) u_cls (
            .demand (demand[g*CNT_W +: CNT_W]),
            .thr_lo (thr_lo),
            .thr_hi (thr_hi),
            .cls    (cls_d[g])
        );
    end

    assign take = (state_q == ST_IDLE) && recompute;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (recompute) state_d = ST_RANK;
            ST_RANK:  state_d = ST_PLACE;
            ST_PLACE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q  <= '0;
            cls_q  <= '0;
            mode_q <= 1'b0;
        end else if (take) begin
            req_q  <= req;
            cls_q  <= cls_d;
            mode_q <= mode_always;
        end
    end

    hp_rank #(.NCORES(NCORES), .RANK_W(RANK_W)) u_rank (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (state_q == ST_RANK),
        .req     (req_q),
        .cls     (cls_q),
        .rank_q  (rank_q),
        .ord_q   (ord_q),
        .cnt_q   (cnt_q),
        .heavy_q (heavy_q)
    );

    hp_place #(.NCORES(NCORES), .NINST(NINST), .RANK_W(RANK_W), .IDX_W(IDX_W)) u_place (
        .mode_always (mode_q),
        .req         (req_q),
        .rank        (rank_q),
        .ord         (ord_q),
        .cnt         (cnt_q),
        .any_heavy   (heavy_q),
        .idx         (idx_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            assign_idx <= '0;
            assign_vld <= '0;
        end else if (state_q == ST_PLACE) begin
            assign_idx <= idx_d;
            assign_vld <= req_q;
        end
    end

    AST_START_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && recompute) |=> (state_q == ST_RANK)); // R8
    AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_PLACE) |=> ($stable(assign_idx) && $stable(assign_vld))); // R8
    AST_BUSY_IGNORES_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(req_q) && $stable(cls_q) && $stable(mode_q))); // R9
    AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PLACE) |=> (assign_vld == $past(req_q))); // R3

    for (genvar g = 0; g < NCORES; g++) begin : g_out_chk
        AST_IDX_IN_POOL: assert property (@(posedge clk) disable iff (!rst_n)
            assign_vld[g] |-> (int'(assign_idx[g*IDX_W +: IDX_W]) < NINST)); // R4
        AST_IDLE_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            !assign_vld[g] |-> (assign_idx[g*IDX_W +: IDX_W] == '0)); // R3
    end

endmodule

// File: tb/tb_hp_assign_top.sv
`timescale 1ns/1ps
module tb_hp_assign_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        recompute = 1'b0;
    logic        mode_always = 1'b0;
    logic [15:0] thr_lo = 16'd100;
    logic [15:0] thr_hi = 16'd1000;
    logic [3:0]  req = '0;
    logic [63:0] demand = '0;
    logic [7:0]  assign_idx;
    logic [3:0]  assign_vld;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    hp_assign_top dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .recompute   (recompute),
        .mode_always (mode_always),
        .thr_lo      (thr_lo),
        .thr_hi      (thr_hi),
        .req         (req),
        .demand      (demand),
        .assign_idx  (assign_idx),
        .assign_vld  (assign_vld)
    );

    localparam logic [15:0] L = 16'd50;
    localparam logic [15:0] M = 16'd500;
    localparam logic [15:0] H = 16'd2000;

    // {mode, req[3:0], d3, d2, d1, d0, exp_vld[3:0], exp_idx[7:0]}
    localparam logic [80:0] VEC [12] = '{
        {1'b0, 4'hF, M, L, H, H,                         4'hF, 8'h14}, // R5 ties
        {1'b1, 4'hF, M, L, H, H,                         4'hF, 8'h54}, // R6
        {1'b1, 4'hF, M, L, M, L,                         4'hF, 8'h11}, // R7
        {1'b0, 4'hF, M, L, M, L,                         4'hF, 8'h50}, // R5
        {1'b0, 4'h6, H, H, H, H,                         4'h6, 8'h10}, // R4
        {1'b1, 4'hB, L, H, H, M,                         4'hB, 8'h41}, // R6 R3
        {1'b0, 4'hB, L, H, H, M,                         4'hB, 8'h01}, // R5 R3
        {1'b1, 4'hF, 16'd1000, 16'd999, 16'd100, 16'd99, 4'hF, 8'h15}, // R2 R6
        {1'b0, 4'hF, 16'd1000, 16'd999, 16'd100, 16'd99, 4'hF, 8'h05}, // R2 R5
        {1'b1, 4'h7, H, L, L, L,                         4'h7, 8'h10}, // R7
        {1'b1, 4'h0, H, H, H, H,                         4'h0, 8'h00}, // R3
        {1'b1, 4'hF, H, H, H, H,                         4'hF, 8'h54}  // R6
    };

    string vtag [12] = '{"R5", "R6", "R7", "R5", "R4", "R6 R3", "R5 R3",
                         "R2 R6", "R2 R5", "R7", "R3", "R6"};

    task automatic chk(input string tag, input logic [11:0] got, input logic [11:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got vld=%h idx=%h expected vld=%h idx=%h",
                     tag, got[11:8], got[7:0], exp[11:8], exp[7:0]);
        end
    endtask

    task automatic strobe(input logic m, input logic [3:0] r, input logic [63:0] d);
        @(negedge clk);
        mode_always = m;
        req         = r;
        demand      = d;
        recompute   = 1'b1;
        @(negedge clk);
        recompute   = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset", {assign_vld, assign_idx}, 12'h000);

        for (int k = 0; k < 12; k++) begin
            thr_lo = 16'd100;
            thr_hi = 16'd1000;
            strobe(VEC[k][80], VEC[k][79:76], VEC[k][75:12]);
            @(negedge clk);
            @(negedge clk);
            chk(vtag[k], {assign_vld, assign_idx}, VEC[k][11:0]);
        end

        // R8: outputs from the last vector (8'h54) hold while inputs change without a strobe
        @(negedge clk);
        req = 4'h1;
        mode_always = 1'b0;
        demand = '0;
        repeat (5) @(negedge clk);
        chk("R8 no strobe", {assign_vld, assign_idx}, 12'hF54);

        // R8: exact update edge
        strobe(1'b1, 4'hF, {M, L, M, L});
        chk("R8 old after one edge", {assign_vld, assign_idx}, 12'hF54);
        @(negedge clk);
        chk("R8 unchanged in place cycle", {assign_vld, assign_idx}, 12'hF54);
        @(negedge clk);
        chk("R8 new after two edges", {assign_vld, assign_idx}, 12'hF11);

        // R9: a second strobe during the rank cycle is dropped
        @(negedge clk);
        mode_always = 1'b1;
        req = 4'hF;
        demand = {H, H, H, H};
        recompute = 1'b1;
        @(negedge clk);
        mode_always = 1'b0;
        req = 4'h1;
        demand = {L, L, L, L};
        recompute = 1'b1;
        @(negedge clk);
        recompute = 1'b0;
        @(negedge clk);
        chk("R9 first strobe result", {assign_vld, assign_idx}, 12'hF54);
        repeat (4) @(negedge clk);
        chk("R9 busy strobe ignored", {assign_vld, assign_idx}, 12'hF54);

        // R10: wider thresholds make all demands medium, so no private heavy instance
        thr_lo = 16'd0;
        thr_hi = 16'd60000;
        strobe(1'b1, 4'hF, {H, H, H, H});
        @(negedge clk);
        @(negedge clk);
        chk("R10 thresholds reprogrammed", {assign_vld, assign_idx}, 12'hF50);

        // R1: reset clears the assignment
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset after use", {assign_vld, assign_idx}, 12'h000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule